// File: doc/BRIEF.md
# Sector-Buffer Controller Register Port

This block is the byte-wide register port of a CD sector-buffer controller. A local CPU reaches every register through one 5-bit index: it loads the index, then reads or writes a byte. The index steps forward by itself after each access, so a run of registers can be read or written without reloading it. Reads and writes use different maps under the same index, and several accesses have side effects. These side effects include releasing interrupt flags, clearing counter bits, starting a transfer and resetting the port.

The block keeps the interface control and status bytes, the transfer byte counter and data address, the sector write address, the block pointer, two control bytes, a bank of four captured header bytes and the decoder status bytes. When the sector decoder reports a finished sector, the block captures its header and marks the decoder flag pending. When sector storing is requested, it also advances the write address and block pointer by one sector and pulses a strobe to the sector writer. A trigger write pulses a start strobe to the transfer engine, and the engine reports back with an end pulse. The block combines the two active-low pending flags into one registered interrupt request, gated by a master enable. All ports are plain control and status pins and there is no streaming interface, so no back-pressure applies.

Top module: `sbc_regport`

## Requirements
- R1: Each read or write advances the index by one, modulo 32. A cycle with `idx_load_i` high loads `idx_val_i` and ignores any read or write strobe in that cycle. When read and write are both high, only the write takes place.
- R2: A read at index 0 or at any index of 16 and above returns 0xFF. A write at an index of 16 and above changes no register.
- R3: Write map: 2/3 set the byte counter low/high, and the high write keeps only its low 4 bits, so counter bits 15:12 become 0. 4/5 set the data address, 8/9 set the write address and 12/13 set the block pointer. Read map: 2/3 return the counter, 8/9 return the block pointer and 10/11 return the write address.
- R4: After `rst` or a write at index 15 (soft reset), the state is as follows. Interface status reads 0xFF at index 1. The header bank 0 reads 00,00,00,01 at indices 4..7. Indices 12, 13 and 14 read 0x00 and index 15 reads 0x80. Both control bytes and the interface control are zero. A soft reset also sets the index to 0.
- R5: Control1 bit 0 selects the header bank read at indices 4..7. Bank 1 always reads zero. Bank 0 holds the last captured header, whose byte 0 (index 4) is `sec_hdr_i[31:24]`.
- R6: `sec_done_i` with control0 bit 7 set does four things: it captures the header, sets status3 (index 15) to 0x00, sets status0 (index 12) to 0x80 and drives the decoder flag (interface status bit 5) low. With control0 bit 7 clear, `sec_done_i` has no effect.
- R7: When control0 bit 2 is also set, a decoded sector adds 2352 to the block pointer and to the write address. It also pulses `sec_store_o` high for exactly the following cycle.
- R8: `irq_o` is registered one cycle after its inputs. It is high only when `irq_en_i` is high and one of two conditions holds: interface control bit 6 is set with status bit 6 low, or interface control bit 5 is set with status bit 5 low.
- R9: A read at index 15 returns status3, and the next state has status3 = 0x80 with the decoder flag released (high).
- R10: A write at index 7 sets the transfer-end flag (status bit 6) high and clears byte-counter bits 15:12.
- R11: A write at index 10 with data bit 7 clear releases the decoder flag.
- R12: On a write to either control byte, status2 (index 14) becomes control1 & 0x08 if control0 bit 4 is set, else control1 & 0x0C. Each write uses the new value of the written byte and the held value of the other.
- R13: The decoder flag releases on its own `DEC_HOLD` cycles after a decoded sector.
- R14: A write at index 6 behaves as follows when interface control bit 1 is set. It pulses `xfer_start_o` for one cycle, drives status bits 3 and 1 low and clears counter bits 15:12. When interface control bit 1 is clear, the same write does nothing. `xfer_end_i` sets status bits 3 and 1 high, drives bit 6 low and sets the counter to 0xFFFF. A write at index 1 with bit 1 clear sets status bits 3 and 1 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_load_i | input | 1 | Load the register index |
| idx_val_i | input | 5 | Index value to load |
| reg_rd_i | input | 1 | Read strobe at the current index |
| reg_wr_i | input | 1 | Write strobe at the current index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data at the current index (combinational) |
| idx_o | output | 5 | Current register index |
| sec_done_i | input | 1 | Sector decoded pulse |
| sec_hdr_i | input | 32 | Header of the decoded sector |
| xfer_end_i | input | 1 | Transfer engine finished pulse |
| irq_en_i | input | 1 | Master interrupt enable |
| irq_o | output | 1 | Combined interrupt request |
| xfer_start_o | output | 1 | Transfer start strobe |
| sec_store_o | output | 1 | Sector store strobe |
| xfer_count_o | output | 16 | Transfer byte counter |
| xfer_addr_o | output | 16 | Transfer data address |
| blk_ptr_o | output | 16 | Block pointer |

## Verification
The main register traffic is tried with seeded random bytes that are written as one auto-incremented run and then read back through the opposite map. Because of this, a read/write map swap, a lost high-nibble mask or a stuck index each shows up as a mismatch. Random pairs of control bytes, written in a fixed order, separate the auto-mode and manual-mode status2 rules. Directed sequences cover the side-effect paths, with each release source tried alone so that a wrong release path cannot be hidden by another one: decode with and without enable, the status3 read, the control0 release, the timer expiry, and trigger/end/acknowledge with the output enable on and off. The out-of-range indices, the wrap from 31 to 0 and the load-versus-access collision are also covered.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int IDX_W = 5;

  // interface status bits (active low)
  localparam int FS_TEND = 6;
  localparam int FS_DEC  = 5;
  localparam int FS_BUSY = 3;
  localparam int FS_DEN  = 1;

  // interface control bits
  localparam int FC_TEND_EN = 6;
  localparam int FC_DEC_EN  = 5;
  localparam int FC_OUT_EN  = 1;

  // control0 bits
  localparam int C0_DECODE = 7;
  localparam int C0_AUTO   = 4;
  localparam int C0_STORE  = 2;

  // control1 bits
  localparam int C1_BANK = 0;

  // write-side register slots
  localparam logic [3:0] W_IFCTL  = 4'h1;
  localparam logic [3:0] W_CNT_L  = 4'h2;
  localparam logic [3:0] W_CNT_H  = 4'h3;
  localparam logic [3:0] W_ADR_L  = 4'h4;
  localparam logic [3:0] W_ADR_H  = 4'h5;
  localparam logic [3:0] W_TRIG   = 4'h6;
  localparam logic [3:0] W_ACK    = 4'h7;
  localparam logic [3:0] W_WA_L   = 4'h8;
  localparam logic [3:0] W_WA_H   = 4'h9;
  localparam logic [3:0] W_CTL0   = 4'hA;
  localparam logic [3:0] W_CTL1   = 4'hB;
  localparam logic [3:0] W_PT_L   = 4'hC;
  localparam logic [3:0] W_PT_H   = 4'hD;
  localparam logic [3:0] W_SRST   = 4'hF;

  localparam logic [31:0] HDR_RESET = 32'h0000_0001;

  function automatic logic [7:0] mode_bits(input logic [7:0] c0, input logic [7:0] c1);
    return c0[C0_AUTO] ? (c1 & 8'h08) : (c1 & 8'h0C);
  endfunction
endpackage

// File: rtl/sbc_index.sv
module sbc_index #(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] load_val,
  input  logic          clr,
  input  logic          step,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= load_val;
    else if (clr)  idx <= '0;
    else if (step) idx <= idx + IW'(1);
  end

  p_index_step_r1: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clr) |=> (idx == $past(idx) + IW'(1)));
endmodule

// File: rtl/sbc_dec_timer.sv
module sbc_dec_timer #(
  parameter int HOLD = 67250
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic release_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= CW'(HOLD);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign release_o = (cnt == CW'(1)) && !start;
endmodule

// File: rtl/sbc_rdmux.sv
module sbc_rdmux
  import sbc_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       ifstat,
  input  logic [15:0]      cnt,
  input  logic [31:0]      hdr0,
  input  logic [31:0]      hdr1,
  input  logic             bank,
  input  logic [15:0]      ptr,
  input  logic [15:0]      waddr,
  input  logic [7:0]       st0,
  input  logic [7:0]       st2,
  input  logic [7:0]       st3,
  output logic [7:0]       rdata
);
  logic [31:0] hsel;
  assign hsel = bank ? hdr1 : hdr0;

  always_comb begin
    rdata = 8'hFF;
    if (!idx[4]) begin
      unique case (idx[3:0])
        4'h0: rdata = 8'hFF;
        4'h1: rdata = ifstat;
        4'h2: rdata = cnt[7:0];
        4'h3: rdata = cnt[15:8];
        4'h4: rdata = hsel[31:24];
        4'h5: rdata = hsel[23:16];
        4'h6: rdata = hsel[15:8];
        4'h7: rdata = hsel[7:0];
        4'h8: rdata = ptr[7:0];
        4'h9: rdata = ptr[15:8];
        4'hA: rdata = waddr[7:0];
        4'hB: rdata = waddr[15:8];
        4'hC: rdata = st0;
        4'hD: rdata = 8'h00;
        4'hE: rdata = st2;
        4'hF: rdata = st3;
        default: rdata = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/sbc_regport.sv
module sbc_regport
  import sbc_pkg::*;
#(
  parameter int DEC_HOLD     = 67250,
  parameter int SECTOR_BYTES = 2352,
  parameter int AW           = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_load_i,
  input  logic [4:0]       idx_val_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic [4:0]       idx_o,
  input  logic             sec_done_i,
  input  logic [31:0]      sec_hdr_i,
  input  logic             xfer_end_i,
  input  logic             irq_en_i,
  output logic             irq_o,
  output logic             xfer_start_o,
  output logic             sec_store_o,
  output logic [AW-1:0]    xfer_count_o,
  output logic [AW-1:0]    xfer_addr_o,
  output logic [AW-1:0]    blk_ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(SECTOR_BYTES);

  logic [IDX_W-1:0] idx;
  logic acc_wr, acc_rd, low_wr, soft_rst, dec_start, dec_release;
  logic [7:0] ifstat_q, ifctl_q, ctl0_q, ctl1_q, st0_q, st2_q, st3_q;
  logic [AW-1:0] cnt_q, adr_q, wa_q, pt_q;
  logic [31:0] hdr0_q, hdr1_q;
  logic irq_q, start_q, store_q;

  assign acc_wr    = reg_wr_i && !idx_load_i;
  assign acc_rd    = reg_rd_i && !reg_wr_i && !idx_load_i;
  assign low_wr    = acc_wr && !idx[4];
  assign soft_rst  = low_wr && (idx[3:0] == W_SRST);
  assign dec_start = sec_done_i && ctl0_q[C0_DECODE];

  sbc_index #(.IW(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .load(idx_load_i), .load_val(idx_val_i),
    .clr(soft_rst), .step(acc_wr || acc_rd), .idx(idx)
  );

  sbc_dec_timer #(.HOLD(DEC_HOLD)) u_tmr (
    .clk(clk), .rst(rst), .start(dec_start), .release_o(dec_release)
  );

  sbc_rdmux u_rd (
    .idx(idx), .ifstat(ifstat_q), .cnt(cnt_q), .hdr0(hdr0_q), .hdr1(hdr1_q),
    .bank(ctl1_q[C1_BANK]), .ptr(pt_q), .waddr(wa_q),
    .st0(st0_q), .st2(st2_q), .st3(st3_q), .rdata(reg_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ifstat_q <= 8'hFF; ifctl_q <= '0; ctl0_q <= '0; ctl1_q <= '0;
      st0_q <= '0; st2_q <= '0; st3_q <= 8'h80;
      cnt_q <= '0; adr_q <= '0; wa_q <= '0; pt_q <= '0;
      hdr0_q <= HDR_RESET; hdr1_q <= '0;
      irq_q <= 1'b0; start_q <= 1'b0; store_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      store_q <= 1'b0;
      if (low_wr) begin
        unique case (idx[3:0])
          W_IFCTL: begin
            if (!reg_wdata_i[FC_OUT_EN]) begin
              ifstat_q[FS_BUSY] <= 1'b1;
              ifstat_q[FS_DEN]  <= 1'b1;
            end
            ifctl_q <= reg_wdata_i;
          end
          W_CNT_L: cnt_q[7:0]  <= reg_wdata_i;
          W_CNT_H: cnt_q[15:8] <= {4'h0, reg_wdata_i[3:0]};
          W_ADR_L: adr_q[7:0]  <= reg_wdata_i;
          W_ADR_H: adr_q[15:8] <= reg_wdata_i;
          W_TRIG: begin
            if (ifctl_q[FC_OUT_EN]) begin
              ifstat_q[FS_BUSY] <= 1'b0;
              ifstat_q[FS_DEN]  <= 1'b0;
              cnt_q[15:12]      <= 4'h0;
              start_q           <= 1'b1;
            end
          end
          W_ACK: begin
            ifstat_q[FS_TEND] <= 1'b1;
            cnt_q[15:12]      <= 4'h0;
          end
          W_WA_L: wa_q[7:0]  <= reg_wdata_i;
          W_WA_H: wa_q[15:8] <= reg_wdata_i;
          W_CTL0: begin
            if (!reg_wdata_i[C0_DECODE]) ifstat_q[FS_DEC] <= 1'b1;
            st2_q  <= mode_bits(reg_wdata_i, ctl1_q);
            ctl0_q <= reg_wdata_i;
          end
          W_CTL1: begin
            st2_q  <= mode_bits(ctl0_q, reg_wdata_i);
            ctl1_q <= reg_wdata_i;
          end
          W_PT_L: pt_q[7:0]  <= reg_wdata_i;
          W_PT_H: pt_q[15:8] <= reg_wdata_i;
          W_SRST: begin
            ifstat_q <= 8'hFF; ifctl_q <= '0; ctl0_q <= '0; ctl1_q <= '0;
            st0_q <= '0; st2_q <= '0; st3_q <= 8'h80;
            hdr0_q <= HDR_RESET;
          end
          default: ;
        endcase
      end
      if (acc_rd && idx == 5'h0F) begin
        st3_q            <= 8'h80;
        ifstat_q[FS_DEC] <= 1'b1;
      end
      if (dec_release) ifstat_q[FS_DEC] <= 1'b1;
      if (xfer_end_i) begin
        ifstat_q[FS_BUSY] <= 1'b1;
        ifstat_q[FS_DEN]  <= 1'b1;
        ifstat_q[FS_TEND] <= 1'b0;
        cnt_q             <= '1;
      end
      if (dec_start) begin
        hdr0_q           <= sec_hdr_i;
        st3_q            <= 8'h00;
        st0_q            <= 8'h80;
        ifstat_q[FS_DEC] <= 1'b0;
        if (ctl0_q[C0_STORE]) begin
          pt_q    <= pt_q + STEP;
          wa_q    <= wa_q + STEP;
          store_q <= 1'b1;
        end
      end
      irq_q <= irq_en_i &&
               ((ifctl_q[FC_TEND_EN] && !ifstat_q[FS_TEND]) ||
                (ifctl_q[FC_DEC_EN]  && !ifstat_q[FS_DEC]));
    end
  end

  assign idx_o        = idx;
  assign irq_o        = irq_q;
  assign xfer_start_o = start_q;
  assign sec_store_o  = store_q;
  assign xfer_count_o = cnt_q;
  assign xfer_addr_o  = adr_q;
  assign blk_ptr_o    = pt_q;

  p_high_read_r2: assert property (@(posedge clk) disable iff (rst)
    idx[4] |-> (reg_rdata_o == 8'hFF));
  p_store_step_r7: assert property (@(posedge clk) disable iff (rst)
    sec_store_o |-> (blk_ptr_o == $past(blk_ptr_o) + STEP));
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_en_i |=> !irq_o);
  p_st3_read_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && idx == 5'h0F && !sec_done_i) |=> (st3_q == 8'h80 && ifstat_q[FS_DEC]));
  p_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (low_wr && idx[3:0] == W_ACK && !xfer_end_i) |=> (ifstat_q[FS_TEND] && cnt_q[15:12] == 4'h0));
  p_dec_off_r11: assert property (@(posedge clk) disable iff (rst)
    (low_wr && idx[3:0] == W_CTL0 && !reg_wdata_i[C0_DECODE] && !sec_done_i) |=> ifstat_q[FS_DEC]);
endmodule

// File: tb/sim_sbc_regport.sv
module sim_sbc_regport;
  localparam int HOLD = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idx_load = 1'b0;
  logic [4:0] idx_val = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] idx;
  logic sec_done = 1'b0;
  logic [31:0] sec_hdr = '0;
  logic xfer_end = 1'b0;
  logic irq_en = 1'b0;
  logic irq, start_o, store_o;
  logic [15:0] cnt_o, adr_o, ptr_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic start_seen;

  always #2 clk = ~clk;

  sbc_regport #(.DEC_HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .idx_load_i(idx_load), .idx_val_i(idx_val),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .idx_o(idx), .sec_done_i(sec_done), .sec_hdr_i(sec_hdr), .xfer_end_i(xfer_end),
    .irq_en_i(irq_en), .irq_o(irq), .xfer_start_o(start_o), .sec_store_o(store_o),
    .xfer_count_o(cnt_o), .xfer_addr_o(adr_o), .blk_ptr_o(ptr_o)
  );

  function automatic logic [7:0] exp_mode(input logic [7:0] c0, input logic [7:0] c1);
    return c0[4] ? (c1 & 8'h08) : (c1 & 8'h0C);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic set_idx(input logic [4:0] v);
    idx_load = 1'b1; idx_val = v;
    @(negedge clk);
    idx_load = 1'b0;
  endtask

  task automatic wr_next(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    start_seen = start_o;
  endtask

  task automatic wr_at(input logic [4:0] i, input logic [7:0] d);
    set_idx(i); wr_next(d);
  endtask

  task automatic rd_next(output logic [7:0] d);
    rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_at(input logic [4:0] i, output logic [7:0] d);
    set_idx(i); rd_next(d);
  endtask

  task automatic decode(input logic [31:0] h);
    sec_done = 1'b1; sec_hdr = h;
    @(negedge clk);
    sec_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic [15:0] sp, sa;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state R4 / R5 / R1 / R2
    eq("R4 idx after reset", idx, 0);
    rd_at(5'h01, b); eq("R4 ifstat", b, 8'hFF);
    set_idx(5'h04);
    rd_next(b); eq("R4 hdr0", b, 0);
    rd_next(b); eq("R4 hdr1", b, 0);
    rd_next(b); eq("R4 hdr2", b, 0);
    rd_next(b); eq("R5 hdr3 bank0", b, 1);
    eq("R1 auto index after 4 reads", idx, 8);
    rd_at(5'h00, b); eq("R2 index 0 reads FF", b, 8'hFF);
    rd_at(5'h0C, b); eq("R4 status0", b, 0);
    rd_next(b); eq("R4 status1", b, 0);
    rd_next(b); eq("R4 status2", b, 0);
    rd_next(b); eq("R4 status3", b, 8'h80);
    eq("R8 irq idle", irq, 0);

    // random register traffic R3 / R12
    for (int i = 0; i < 12; i++) begin
      logic [7:0] lo, hi, al, ah, wl, wh, pl, ph, c0, c1;
      lo = 8'($urandom); hi = 8'($urandom); al = 8'($urandom); ah = 8'($urandom);
      wl = 8'($urandom); wh = 8'($urandom); pl = 8'($urandom); ph = 8'($urandom);
      c0 = 8'($urandom) & 8'h7F; c1 = 8'($urandom);
      set_idx(5'h02);
      wr_next(lo); wr_next(hi); wr_next(al); wr_next(ah);
      eq("R3 counter port", cnt_o, {4'h0, hi[3:0], lo});
      eq("R3 data address", adr_o, {ah, al});
      rd_at(5'h02, b); eq("R3 counter low", b, lo);
      rd_next(b); eq("R3 counter high", b, {4'h0, hi[3:0]});
      set_idx(5'h08); wr_next(wl); wr_next(wh);
      set_idx(5'h0C); wr_next(pl); wr_next(ph);
      set_idx(5'h08);
      rd_next(b); eq("R3 ptr low", b, pl);
      rd_next(b); eq("R3 ptr high", b, ph);
      rd_next(b); eq("R3 wa low", b, wl);
      rd_next(b); eq("R3 wa high", b, wh);
      set_idx(5'h0A); wr_next(c0); wr_next(c1);
      rd_at(5'h0E, b); eq("R12 status2 random", b, exp_mode(c0, c1));
      eq("R1 index after read at 14", idx, 5'h0F);
    end

    // load wins over access R1
    idx_load = 1'b1; idx_val = 5'h09; rd = 1'b1;
    @(negedge clk);
    idx_load = 1'b0; rd = 1'b0;
    eq("R1 load priority", idx, 5'h09);
    wr = 1'b1; rd = 1'b1; wdata = 8'h00;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    eq("R1 read+write steps once", idx, 5'h0A);

    // high indices R2
    sp = ptr_o; sa = adr_o;
    wr_at(5'h12, 8'hAA);
    eq("R1 index after write at 0x12", idx, 5'h13);
    rd_next(b); eq("R2 read at 0x13", b, 8'hFF);
    wr_at(5'h1F, 8'h55);
    eq("R1 wrap to 0", idx, 0);
    eq("R2 ptr untouched", ptr_o, sp);
    eq("R2 address untouched", adr_o, sa);
    rd_at(5'h01, b); eq("R2 ifstat untouched", b, 8'hFF);

    // status2 directed R12
    wr_at(5'h0A, 8'h00); wr_at(5'h0B, 8'h0C);
    rd_at(5'h0E, b); eq("R12 manual mode+form", b, 8'h0C);
    wr_at(5'h0A, 8'h10);
    rd_at(5'h0E, b); eq("R12 auto on ctl0 write", b, 8'h08);
    wr_at(5'h0B, 8'h04);
    rd_at(5'h0E, b); eq("R12 auto drops form", b, 8'h00);
    wr_at(5'h0B, 8'h00);

    // decode R6 / R7 / R5 / R8 / R9
    irq_en = 1'b1;
    wr_at(5'h01, 8'h20);
    wr_at(5'h0A, 8'h00);
    decode(32'hDEADBEEF);
    @(negedge clk);
    eq("R6 disabled decode no irq", irq, 0);
    rd_at(5'h07, b); eq("R6 disabled decode keeps header", b, 8'h01);
    set_idx(5'h0C); wr_next(8'h00); wr_next(8'h01);
    set_idx(5'h08); wr_next(8'h00); wr_next(8'h02);
    wr_at(5'h0A, 8'h84);
    sec_done = 1'b1; sec_hdr = 32'h11223344;
    @(negedge clk);
    sec_done = 1'b0;
    eq("R7 store strobe", store_o, 1);
    @(negedge clk);
    eq("R7 store strobe one cycle", store_o, 0);
    eq("R7 ptr advanced", ptr_o, 16'h0A30);
    eq("R8 decoder irq", irq, 1);
    set_idx(5'h04);
    rd_next(b); eq("R5 bank0 byte0", b, 8'h11);
    rd_next(b); eq("R5 bank0 byte1", b, 8'h22);
    rd_next(b); eq("R5 bank0 byte2", b, 8'h33);
    rd_next(b); eq("R5 bank0 byte3", b, 8'h44);
    wr_at(5'h0B, 8'h01);
    rd_at(5'h04, b); eq("R5 bank1 zero", b, 0);
    wr_at(5'h0B, 8'h00);
    rd_at(5'h0A, b); eq("R7 wa low", b, 8'h30);
    rd_next(b); eq("R7 wa high", b, 8'h0B);
    rd_next(b); eq("R6 status0", b, 8'h80);
    rd_at(5'h01, b); eq("R6 decoder flag low", b & 8'h20, 0);
    irq_en = 1'b0; @(negedge clk); @(negedge clk);
    eq("R8 master gate off", irq, 0);
    irq_en = 1'b1; @(negedge clk); @(negedge clk);
    eq("R8 master gate on", irq, 1);
    rd_at(5'h0F, b); eq("R9 status3 returns pending", b, 0);
    @(negedge clk);
    eq("R9 irq released by status3 read", irq, 0);
    rd_at(5'h0F, b); eq("R9 status3 restored", b, 8'h80);

    // control0 release R11
    decode(32'h0);
    @(negedge clk);
    eq("R11 irq before release", irq, 1);
    wr_at(5'h0A, 8'h04);
    @(negedge clk);
    eq("R11 control0 release", irq, 0);

    // timer R13
    wr_at(5'h0A, 8'h80);
    decode(32'h0);
    repeat (HOLD - 3) @(negedge clk);
    eq("R13 still pending", irq, 1);
    repeat (6) @(negedge clk);
    eq("R13 auto released", irq, 0);

    // transfer R14 / R10
    wr_at(5'h0A, 8'h00);
    wr_at(5'h01, 8'h42);
    wr_at(5'h06, 8'h00);
    eq("R14 start strobe", start_seen, 1);
    rd_at(5'h01, b); eq("R14 busy status", b, 8'hF5);
    xfer_end = 1'b1; @(negedge clk); xfer_end = 1'b0;
    rd_at(5'h01, b); eq("R14 end status", b, 8'hBF);
    eq("R14 counter all ones", cnt_o, 16'hFFFF);
    eq("R8 transfer-end irq", irq, 1);
    wr_at(5'h07, 8'h00);
    @(negedge clk);
    rd_at(5'h01, b); eq("R10 ack releases flag", b, 8'hFF);
    eq("R10 ack clears top nibble", cnt_o, 16'h0FFF);
    eq("R10 irq after ack", irq, 0);
    wr_at(5'h01, 8'h40);
    wr_at(5'h06, 8'h00);
    eq("R14 trigger ignored without output enable", start_seen, 0);
    rd_at(5'h01, b); eq("R14 status unchanged", b, 8'hFF);
    wr_at(5'h01, 8'h42); wr_at(5'h06, 8'h00); wr_at(5'h01, 8'h40);
    rd_at(5'h01, b); eq("R14 disable aborts", b, 8'hFF);

    // soft reset R4
    decode(32'h0);
    wr_at(5'h0A, 8'h80); wr_at(5'h0B, 8'h0D);
    decode(32'hCAFEF00D);
    wr_at(5'h0F, 8'h00);
    eq("R4 soft reset index", idx, 0);
    set_idx(5'h04);
    rd_next(b); eq("R4 soft hdr0", b, 0);
    rd_next(b); eq("R4 soft hdr1", b, 0);
    rd_next(b); eq("R4 soft hdr2", b, 0);
    rd_next(b); eq("R4 soft hdr3", b, 1);
    rd_at(5'h0E, b); eq("R4 soft status2", b, 0);
    rd_next(b); eq("R4 soft status3", b, 8'h80);
    rd_at(5'h01, b); eq("R4 soft ifstat", b, 8'hFF);
    rd_at(5'h0C, b); eq("R4 soft status0", b, 0);

    finish_run();
  end
endmodule